// File: doc/BRIEF.md
# Standby Mode Controller

This block sequences a small microcontroller between its run modes and its two sleep modes. Software requests a sleep mode by writing the low-power control bits. It also writes the clock-select bits that name the running clock: main oscillator, PLL or sub-clock. The controller then gates the CPU clock, main oscillator, PLL, sub-oscillator and watch timer. It drives the pin high-impedance control and reports its current state on a status output. The whole block is clocked from the always-running sub-clock, so it keeps working while the main oscillator is off.

The states are RUN_MAIN, RUN_PLL, RUN_SUB, WATCH, STOP, WAIT_STAB and RESET_SEQ. The transitions are:
- run to run when the clock select changes;
- run to WATCH on a watch request, and run to STOP on a stop request;
- any run state to RESET_SEQ on a reset request;
- WATCH to RUN_SUB or RESET_SEQ when the sleep was entered from the sub-clock;
- WATCH or STOP to WAIT_STAB when the sleep was entered from the main or PLL clock, and always from STOP;
- WAIT_STAB back to the saved run state, or to RESET_SEQ if a reset request arrived;
- RESET_SEQ to RUN_MAIN.

A request written while an enabled interrupt is pending is dropped. Wake-up comes from an enabled interrupt or a reset request. Waking from sub-clock watch returns to the sub-clock at once. Waking from any other sleep first waits out a programmable stabilization count on the sub-clock.

Top module: `stby_ctrl`

## Requirements
- R1: After rst_n is released, mode_state is 0 (RUN_MAIN), io_hiz is 0, and the clock select is restored to the main oscillator. The gates {gate_cpu,gate_main,gate_pll,gate_sub,gate_wtimer} read 11011.
- R2: A stop request is lpm_we with lpm_stop=1. It is taken only while the stored clock select is clk_sub_n=0, clk_pll_n=1; otherwise it is ignored. STOP is mode_state 4 and turns all five gates off (00000).
- R3: A watch or stop request written in the same cycle as an enabled interrupt request leaves the block in its run state.
- R4: io_hiz equals the lpm_hiz bit stored at the last lpm_we write, but only while in WATCH or STOP. It drops to 0 in the first cycle after leaving the sleep state.
- R5: A watch request is lpm_we with lpm_watch_n=0, and it moves a run state to WATCH (mode_state 3). WATCH gates read 00011: the CPU, main and PLL clocks are off, and the sub-oscillator and watch timer stay on.
- R6: WATCH entered from RUN_SUB exits straight to RUN_SUB (2) on an enabled interrupt. It exits straight to RESET_SEQ (6) on rst_req.
- R7: WATCH entered from RUN_MAIN or RUN_PLL, and every STOP, exits on wake to WAIT_STAB (mode_state 5, gates 01011). Unless a reset was requested, the block then returns to the run state it slept from.
- R8: Interrupt line i is enabled when irq_req[i] is 1 and its 3-bit level irq_lvl[3i+2:3i] is below 7. A line at level 7 neither wakes nor cancels.
- R9: WAIT_STAB lasts stab_limit+1 cycles when osc_stable is high. It lasts longer if osc_stable is low at the end of the count, and it leaves one cycle after osc_stable rises.
- R10: rst_req in a run state, or during a WAIT_STAB exit, leads to RESET_SEQ. RESET_SEQ lasts RST_LEN cycles with gates 10011 (the sub-clock drives the CPU) and then enters RUN_MAIN with the clock select back at main and the pin-hold bit cleared.
- R11: In a run state, a clock-select write moves mode_state to the matching run state two clock edges after the write strobe. The mapping is clk_sub_n=0 to RUN_SUB (gates 10011), else clk_pll_n=0 to RUN_PLL (1, gates 11111), else RUN_MAIN.
- R12: mode_state always shows the state code 0 to 6 in the order RUN_MAIN, RUN_PLL, RUN_SUB, WATCH, STOP, WAIT_STAB, RESET_SEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpm_we | input | 1 | Write strobe for the low-power control bits |
| lpm_watch_n | input | 1 | 0 with lpm_we requests watch mode |
| lpm_stop | input | 1 | 1 with lpm_we requests stop mode |
| lpm_hiz | input | 1 | Stored by lpm_we: 1 floats pins during sleep |
| clk_we | input | 1 | Write strobe for the clock-select bits |
| clk_sub_n | input | 1 | 0 selects the sub-clock |
| clk_pll_n | input | 1 | 0 selects the PLL when the sub-clock is not selected |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_lvl | input | NIRQ*3 | 3-bit priority level per line, 7 means disabled |
| rst_req | input | 1 | Synchronous reset request (wake source) |
| osc_stable | input | 1 | Main oscillator reports a stable output |
| stab_limit | input | STAB_W | Terminal count of the stabilization wait |
| gate_cpu | output | 1 | CPU clock enable |
| gate_main | output | 1 | Main oscillator enable |
| gate_pll | output | 1 | PLL enable |
| gate_sub | output | 1 | Sub-oscillator enable |
| gate_wtimer | output | 1 | Watch timer clock enable |
| io_hiz | output | 1 | Pins to high impedance |
| mode_state | output | 3 | Current state code |

## Verification
The assertions check several transitions on every cycle:
- a request written with an enabled interrupt pending never reaches a sleep state;
- sub-clock watch exits to RUN_SUB, and other watches exit to WAIT_STAB;
- WAIT_STAB is never left before the counter and osc_stable agree;
- RESET_SEQ always ends in RUN_MAIN.

Only the bench scenarios show the exact lengths of the waits, the return to the saved clock source after stop, and the effect of level-7 lines. They also show the pin-hold bit, the dropped stop request under the wrong clock select, and the restored defaults after a reset sequence.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN_MAIN  = 3'd0,
        ST_RUN_PLL   = 3'd1,
        ST_RUN_SUB   = 3'd2,
        ST_WATCH     = 3'd3,
        ST_STOP      = 3'd4,
        ST_WAIT_STAB = 3'd5,
        ST_RESET_SEQ = 3'd6
    } stby_state_e;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } clk_src_e;

    typedef struct packed {
        logic cpu;
        logic main;
        logic pll;
        logic sub;
        logic wt;
    } gate_t;

endpackage

// File: rtl/stby_irq_qual.sv
module stby_irq_qual #(
    parameter int NIRQ  = 4,
    parameter int LVL_W = 3
) (
    input  logic [NIRQ-1:0]       irq_req,
    input  logic [NIRQ*LVL_W-1:0] irq_lvl,
    output logic                  wake
);
    localparam logic [LVL_W-1:0] LVL_OFF = {LVL_W{1'b1}};

    logic [NIRQ-1:0] hit;

    generate
        for (genvar i = 0; i < NIRQ; i++) begin : g_line
            assign hit[i] = irq_req[i] && (irq_lvl[i*LVL_W +: LVL_W] < LVL_OFF);
        end
    endgenerate

    assign wake = |hit;

    // R8: with no request raised, nothing can wake the device
    always_comb begin
        if (irq_req == '0) begin
            a_r8_quiet_lines: assert (!wake);
        end
    end
endmodule

// File: rtl/stby_cnt.sv
module stby_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q >= limit);

    // R9: the cycle after a clear the count cannot be finished unless the limit is zero
    a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear) && !clear && limit != '0) |-> !done);
endmodule

// File: rtl/stby_cfg.sv
module stby_cfg
    import stby_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_clr,
    input  logic     lpm_we,
    input  logic     lpm_hiz,
    input  logic     clk_we,
    input  logic     clk_sub_n,
    input  logic     clk_pll_n,
    output logic     spl_q,
    output clk_src_e sel_src,
    output logic     stop_ok
);
    logic sub_n_q;
    logic pll_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spl_q   <= 1'b0;
            sub_n_q <= 1'b1;
            pll_n_q <= 1'b1;
        end else if (soft_clr) begin
            spl_q   <= 1'b0;
            sub_n_q <= 1'b1;
            pll_n_q <= 1'b1;
        end else begin
            if (lpm_we) begin
                spl_q <= lpm_hiz;
            end
            if (clk_we) begin
                sub_n_q <= clk_sub_n;
                pll_n_q <= clk_pll_n;
            end
        end
    end

    always_comb begin
        if (!sub_n_q) begin
            sel_src = SRC_SUB;
        end else if (!pll_n_q) begin
            sel_src = SRC_PLL;
        end else begin
            sel_src = SRC_MAIN;
        end
    end

    assign stop_ok = !sub_n_q && pll_n_q;

    // R10: a soft clear always returns the selection to the main oscillator
    a_r10_cfg_default: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_clr) |-> (sel_src == SRC_MAIN && !spl_q));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lpm_we,
    input  logic        lpm_watch_n,
    input  logic        lpm_stop,
    input  logic        rst_req,
    input  logic        wake,
    input  clk_src_e    sel_src,
    input  logic        stop_ok,
    input  logic        spl,
    input  logic        stab_done,
    input  logic        osc_stable,
    input  logic        rseq_done,
    output stby_state_e state_q,
    output gate_t       gates,
    output logic        io_hiz,
    output logic        stab_clear,
    output logic        rseq_clear,
    output logic        cfg_clr
);
    stby_state_e nxt;
    clk_src_e    src_q;
    clk_src_e    cur_src;
    logic        rst_pend_q;
    logic        in_run;
    logic        watch_req;
    logic        stop_req;

    function automatic stby_state_e run_of(clk_src_e s);
        unique case (s)
            SRC_PLL: run_of = ST_RUN_PLL;
            SRC_SUB: run_of = ST_RUN_SUB;
            default: run_of = ST_RUN_MAIN;
        endcase
    endfunction

    assign in_run    = (state_q == ST_RUN_MAIN) || (state_q == ST_RUN_PLL) ||
                       (state_q == ST_RUN_SUB);
    assign watch_req = lpm_we && !lpm_watch_n;
    assign stop_req  = lpm_we && lpm_stop && stop_ok;

    always_comb begin
        unique case (state_q)
            ST_RUN_PLL: cur_src = SRC_PLL;
            ST_RUN_SUB: cur_src = SRC_SUB;
            default:    cur_src = SRC_MAIN;
        endcase
    end

    // next-state decode
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_RUN_MAIN, ST_RUN_PLL, ST_RUN_SUB: begin
                if (rst_req) begin
                    nxt = ST_RESET_SEQ;
                end else if (stop_req && !wake) begin
                    nxt = ST_STOP;
                end else if (watch_req && !wake) begin
                    nxt = ST_WATCH;
                end else begin
                    nxt = run_of(sel_src);
                end
            end
            ST_WATCH: begin
                if (rst_req || wake) begin
                    if (src_q == SRC_SUB) begin
                        nxt = rst_req ? ST_RESET_SEQ : ST_RUN_SUB;
                    end else begin
                        nxt = ST_WAIT_STAB;
                    end
                end
            end
            ST_STOP: begin
                if (rst_req || wake) begin
                    nxt = ST_WAIT_STAB;
                end
            end
            ST_WAIT_STAB: begin
                if (stab_done && osc_stable) begin
                    nxt = (rst_pend_q || rst_req) ? ST_RESET_SEQ : run_of(src_q);
                end
            end
            ST_RESET_SEQ: begin
                if (rseq_done) begin
                    nxt = ST_RUN_MAIN;
                end
            end
            default: nxt = ST_RUN_MAIN;
        endcase
    end

    // state register with saved source and pending reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN_MAIN;
            src_q      <= SRC_MAIN;
            rst_pend_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (in_run && nxt == ST_STOP) begin
                src_q <= SRC_SUB;
            end else if (in_run && nxt == ST_WATCH) begin
                src_q <= cur_src;
            end
            if (nxt != ST_WAIT_STAB) begin
                rst_pend_q <= 1'b0;
            end else if (rst_req) begin
                rst_pend_q <= 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        gates = '0;
        unique case (state_q)
            ST_RUN_MAIN:  gates = '{cpu: 1'b1, main: 1'b1, pll: 1'b0, sub: 1'b1, wt: 1'b1};
            ST_RUN_PLL:   gates = '{cpu: 1'b1, main: 1'b1, pll: 1'b1, sub: 1'b1, wt: 1'b1};
            ST_RUN_SUB:   gates = '{cpu: 1'b1, main: 1'b0, pll: 1'b0, sub: 1'b1, wt: 1'b1};
            ST_WATCH:     gates = '{cpu: 1'b0, main: 1'b0, pll: 1'b0, sub: 1'b1, wt: 1'b1};
            ST_STOP:      gates = '{cpu: 1'b0, main: 1'b0, pll: 1'b0, sub: 1'b0, wt: 1'b0};
            ST_WAIT_STAB: gates = '{cpu: 1'b0, main: 1'b1, pll: 1'b0, sub: 1'b1, wt: 1'b1};
            ST_RESET_SEQ: gates = '{cpu: 1'b1, main: 1'b0, pll: 1'b0, sub: 1'b1, wt: 1'b1};
            default:      gates = '0;
        endcase
    end

    assign io_hiz     = spl && ((state_q == ST_WATCH) || (state_q == ST_STOP));
    assign stab_clear = (state_q != ST_WAIT_STAB);
    assign rseq_clear = (state_q != ST_RESET_SEQ);
    assign cfg_clr    = (state_q == ST_RESET_SEQ) && rseq_done;

    // R3: a request written alongside an enabled interrupt never sleeps
    a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && lpm_we && wake && !rst_req) |=> (state_q != ST_WATCH && state_q != ST_STOP));

    // R6: sub-clock watch returns straight to the sub-clock on an interrupt
    a_r6_sub_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && src_q == SRC_SUB && wake && !rst_req) |=> (state_q == ST_RUN_SUB));

    // R7: main or PLL watch always passes through the stabilization wait
    a_r7_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && src_q != SRC_SUB && (wake || rst_req)) |=> (state_q == ST_WAIT_STAB));

    // R9: the wait is left only with both the count and the oscillator ready
    a_r9_leave_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAIT_STAB && state_q != ST_WAIT_STAB) |-> $past(stab_done && osc_stable));

    // R4: pins are released once the sleep state is left
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_WATCH || $past(state_q) == ST_STOP) &&
         state_q != ST_WATCH && state_q != ST_STOP) |-> !io_hiz);

    // R10: the reset sequence always ends in main run
    a_r10_rseq_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RESET_SEQ && state_q != ST_RESET_SEQ) |-> (state_q == ST_RUN_MAIN));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int NIRQ    = 4,
    parameter int STAB_W  = 8,
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpm_we,
    input  logic              lpm_watch_n,
    input  logic              lpm_stop,
    input  logic              lpm_hiz,
    input  logic              clk_we,
    input  logic              clk_sub_n,
    input  logic              clk_pll_n,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ*3-1:0] irq_lvl,
    input  logic              rst_req,
    input  logic              osc_stable,
    input  logic [STAB_W-1:0] stab_limit,
    output logic              gate_cpu,
    output logic              gate_main,
    output logic              gate_pll,
    output logic              gate_sub,
    output logic              gate_wtimer,
    output logic              io_hiz,
    output logic [2:0]        mode_state
);
    localparam int LVL_W = 3;
    localparam int RST_W = $clog2(RST_LEN + 1);
    localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_LEN - 1);

    logic        wake;
    logic        spl_q;
    clk_src_e    sel_src;
    logic        stop_ok;
    logic        stab_done;
    logic        rseq_done;
    logic        stab_clear;
    logic        rseq_clear;
    logic        cfg_clr;
    stby_state_e state_q;
    gate_t       gates;

    stby_irq_qual #(.NIRQ(NIRQ), .LVL_W(LVL_W)) u_irq (
        .irq_req (irq_req),
        .irq_lvl (irq_lvl),
        .wake    (wake)
    );

    stby_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (cfg_clr),
        .lpm_we    (lpm_we),
        .lpm_hiz   (lpm_hiz),
        .clk_we    (clk_we),
        .clk_sub_n (clk_sub_n),
        .clk_pll_n (clk_pll_n),
        .spl_q     (spl_q),
        .sel_src   (sel_src),
        .stop_ok   (stop_ok)
    );

    stby_cnt #(.W(STAB_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stab_clear),
        .limit (stab_limit),
        .done  (stab_done)
    );

    stby_cnt #(.W(RST_W)) u_rseq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rseq_clear),
        .limit (RST_LAST),
        .done  (rseq_done)
    );

    stby_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lpm_we      (lpm_we),
        .lpm_watch_n (lpm_watch_n),
        .lpm_stop    (lpm_stop),
        .rst_req     (rst_req),
        .wake        (wake),
        .sel_src     (sel_src),
        .stop_ok     (stop_ok),
        .spl         (spl_q),
        .stab_done   (stab_done),
        .osc_stable  (osc_stable),
        .rseq_done   (rseq_done),
        .state_q     (state_q),
        .gates       (gates),
        .io_hiz      (io_hiz),
        .stab_clear  (stab_clear),
        .rseq_clear  (rseq_clear),
        .cfg_clr     (cfg_clr)
    );

    assign gate_cpu    = gates.cpu;
    assign gate_main   = gates.main;
    assign gate_pll    = gates.pll;
    assign gate_sub    = gates.sub;
    assign gate_wtimer = gates.wt;
    assign mode_state  = state_q;

    // R2: stop is only reached when the sub-clock selection allowed it
    a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_STOP && state_q == ST_STOP) |-> $past(stop_ok && lpm_we && lpm_stop));
endmodule

// File: tb/stby_ctrl_tb_top.sv
module stby_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 4;
    localparam int RST_LEN    = 4;
    localparam int STAB       = 5;

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic [5:0] outs;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lpm_we, lpm_watch_n, lpm_stop, lpm_hiz;
    logic              clk_we, clk_sub_n, clk_pll_n;
    logic [NIRQ-1:0]   irq_req;
    logic [NIRQ*3-1:0] irq_lvl;
    logic              rst_req, osc_stable;
    logic [7:0]        stab_limit;
    logic              gate_cpu, gate_main, gate_pll, gate_sub, gate_wtimer, io_hiz;
    logic [2:0]        mode_state;

    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_ctrl #(.NIRQ(NIRQ), .STAB_W(8), .RST_LEN(RST_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lpm_we(lpm_we), .lpm_watch_n(lpm_watch_n), .lpm_stop(lpm_stop), .lpm_hiz(lpm_hiz),
        .clk_we(clk_we), .clk_sub_n(clk_sub_n), .clk_pll_n(clk_pll_n),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .rst_req(rst_req),
        .osc_stable(osc_stable), .stab_limit(stab_limit),
        .gate_cpu(gate_cpu), .gate_main(gate_main), .gate_pll(gate_pll),
        .gate_sub(gate_sub), .gate_wtimer(gate_wtimer), .io_hiz(io_hiz),
        .mode_state(mode_state)
    );

    // state codes from R12, gate patterns from R1, R2, R5, R7, R10, R11
    function automatic logic [4:0] gates_for(logic [2:0] s);
        case (s)
            3'd0:    gates_for = 5'b11011;
            3'd1:    gates_for = 5'b11111;
            3'd2:    gates_for = 5'b10011;
            3'd3:    gates_for = 5'b00011;
            3'd4:    gates_for = 5'b00000;
            3'd5:    gates_for = 5'b01011;
            default: gates_for = 5'b10011;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(string tag, logic [2:0] s, logic hiz);
        item_t it;
        it.tag  = tag;
        it.st   = s;
        it.outs = {gates_for(s), hiz};
        sb_q.push_back(it);
    endtask

    task automatic set_irq(int line, logic [2:0] lvl, logic req);
        irq_lvl[line*3 +: 3] = lvl;
        irq_req[line]        = req;
    endtask

    task automatic clear_irq();
        irq_req = '0;
        irq_lvl = '1;
    endtask

    task automatic write_lpm(logic watch_n, logic stop, logic hiz);
        lpm_we = 1'b1; lpm_watch_n = watch_n; lpm_stop = stop; lpm_hiz = hiz;
        tick();
        lpm_we = 1'b0; lpm_watch_n = 1'b1; lpm_stop = 1'b0;
    endtask

    task automatic write_clk(logic sub_n, logic pll_n);
        clk_we = 1'b1; clk_sub_n = sub_n; clk_pll_n = pll_n;
        tick();
        clk_we = 1'b0;
    endtask

    task automatic pulse_rst();
        rst_req = 1'b1;
        tick();
        rst_req = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it  = sb_q.pop_front();
            got = {gate_cpu, gate_main, gate_pll, gate_sub, gate_wtimer, io_hiz};
            total++;
            if (mode_state !== it.st || got !== it.outs) begin
                bad++;
                $display("FAIL %s: got state=%0d outs=%b, expected state=%0d outs=%b",
                         it.tag, mode_state, got, it.st, it.outs);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lpm_we = 1'b0; lpm_watch_n = 1'b1; lpm_stop = 1'b0; lpm_hiz = 1'b0;
        clk_we = 1'b0; clk_sub_n = 1'b1; clk_pll_n = 1'b1;
        irq_req = '0; irq_lvl = '1;
        rst_req = 1'b0; osc_stable = 1'b1; stab_limit = 8'(STAB);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_st("R1 reset state", 3'd0, 1'b0);

        // main watch with pins floated
        write_lpm(1'b0, 1'b0, 1'b1);
        expect_st("R5 watch entry from main", 3'd3, 1'b1);
        expect_st("R4 pins float in watch", 3'd3, 1'b1);
        set_irq(2, 3'd7, 1'b1);
        tick(); tick();
        expect_st("R8 level 7 does not wake", 3'd3, 1'b1);
        set_irq(2, 3'd3, 1'b1);
        tick();
        clear_irq();
        expect_st("R7 main watch waits for stabilization, R4 released", 3'd5, 1'b0);
        repeat (STAB) tick();
        expect_st("R9 still waiting at the terminal count", 3'd5, 1'b0);
        tick();
        expect_st("R9 back to main run", 3'd0, 1'b0);

        // oscillator late
        write_lpm(1'b0, 1'b0, 1'b0);
        expect_st("R4 pins held with hold bit clear", 3'd3, 1'b0);
        osc_stable = 1'b0;
        set_irq(0, 3'd0, 1'b1);
        tick();
        clear_irq();
        repeat (10) tick();
        expect_st("R9 waits for osc_stable", 3'd5, 1'b0);
        osc_stable = 1'b1;
        tick();
        expect_st("R9 leaves once oscillator stable", 3'd0, 1'b0);

        // cancel by pending interrupt
        set_irq(1, 3'd1, 1'b1);
        write_lpm(1'b0, 1'b0, 1'b1);
        expect_st("R3 watch cancelled by pending interrupt", 3'd0, 1'b0);
        clear_irq();
        write_lpm(1'b1, 1'b0, 1'b0);
        expect_st("R5 write without request keeps run", 3'd0, 1'b0);

        // PLL watch and reset exit
        write_clk(1'b1, 1'b0);
        tick();
        expect_st("R11 switch to PLL run", 3'd1, 1'b0);
        write_lpm(1'b0, 1'b0, 1'b0);
        expect_st("R5 watch entry from PLL", 3'd3, 1'b0);
        pulse_rst();
        expect_st("R10 reset wake from PLL watch waits first", 3'd5, 1'b0);
        repeat (STAB) tick();
        expect_st("R10 still waiting before reset sequence", 3'd5, 1'b0);
        tick();
        expect_st("R10 reset sequence on sub-clock", 3'd6, 1'b0);
        repeat (RST_LEN - 1) tick();
        expect_st("R10 reset sequence length", 3'd6, 1'b0);
        tick();
        expect_st("R10 reset sequence ends in main run", 3'd0, 1'b0);
        tick();
        expect_st("R10 clock select restored to main", 3'd0, 1'b0);

        // stop refused with main selected
        write_lpm(1'b1, 1'b1, 1'b1);
        expect_st("R2 stop ignored without sub selection", 3'd0, 1'b0);

        // sub watch
        write_clk(1'b0, 1'b1);
        tick();
        expect_st("R11 switch to sub run", 3'd2, 1'b0);
        write_lpm(1'b0, 1'b0, 1'b0);
        expect_st("R5 watch entry from sub", 3'd3, 1'b0);
        set_irq(3, 3'd6, 1'b1);
        tick();
        clear_irq();
        expect_st("R6 sub watch returns directly to sub run", 3'd2, 1'b0);
        write_lpm(1'b0, 1'b0, 1'b0);
        pulse_rst();
        expect_st("R6 sub watch reset goes straight to reset sequence", 3'd6, 1'b0);
        repeat (RST_LEN) tick();
        expect_st("R10 back to main after sub reset", 3'd0, 1'b0);

        // stop and return to sub
        write_clk(1'b0, 1'b1);
        tick();
        expect_st("R11 sub run before stop", 3'd2, 1'b0);
        write_lpm(1'b1, 1'b1, 1'b1);
        expect_st("R2 stop entry, all gates off, R4 pins float", 3'd4, 1'b1);
        set_irq(0, 3'd7, 1'b1);
        tick();
        expect_st("R8 level 7 does not end stop", 3'd4, 1'b1);
        set_irq(0, 3'd4, 1'b1);
        tick();
        clear_irq();
        expect_st("R7 stop exit waits for stabilization", 3'd5, 1'b0);
        repeat (STAB + 1) tick();
        expect_st("R7 stop returns to sub run", 3'd2, 1'b0);

        // reset from run
        pulse_rst();
        expect_st("R10 reset request in run", 3'd6, 1'b0);
        repeat (RST_LEN) tick();
        expect_st("R12 final code main run", 3'd0, 1'b0);

        tick();
        tick();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule